// File: doc/BRIEF.md
# Serial Flash Status-Register Write Controller

This block is the slave-side command logic that a serial flash device uses to guard and update its status register over a mode-0 SPI link. The host lowers chip select, clocks in an 8-bit opcode most significant bit first (sampled on rising serial clock), and optionally a data byte. Three opcodes are understood: a write-enable command, a status-write command and a status-read command. The status register carries a busy flag, a write-enable latch, a three-bit block-protect field and a write-disable bit.

A status write only takes effect if four conditions hold together. The write-enable latch must already be set. Chip select must rise directly after the eighth data bit. The device must not be busy. The device must not be hardware-protected, which is the case when the write-disable bit is 1 while the write-protect pin is low. An accepted write updates the protect bits at once and starts a self-timed busy period of `WRITE_CYCLES` system clocks. At the end of that period the busy flag and the write-enable latch both clear. The status-read command streams the register out continuously, taking a fresh copy every eight bits, so the host can poll the busy flag within a single frame.

The pins are oversampled by a system clock through a `SYNC_STAGES`-deep synchronizer. The control is one state machine with these states:
- `ST_IDLE`: chip select high.
- `ST_OPCODE`: collecting the opcode.
- `ST_WREN_END`: write-enable received, waiting for chip select to rise.
- `ST_WRSR_DATA`: collecting the status data byte.
- `ST_WRSR_END`: data byte received, waiting for chip select to rise.
- `ST_READ`: streaming the status register out.
- `ST_DISCARD`: the rest of the frame is ignored.

Its transitions are:
- Any state goes to `ST_IDLE` when chip select goes high.
- `ST_IDLE` goes to `ST_OPCODE` once chip select is low.
- `ST_OPCODE` leaves when its byte completes. It goes to `ST_READ` on the read opcode. It goes to `ST_WREN_END` or `ST_WRSR_DATA` on the enable or write opcode when not busy. It goes to `ST_DISCARD` otherwise.
- `ST_WRSR_DATA` goes to `ST_WRSR_END` when the data byte completes.
- `ST_WREN_END` and `ST_WRSR_END` go to `ST_DISCARD` on any further rising serial clock.

The rising edge of chip select commits the write-enable latch from `ST_WREN_END`, or the status write from `ST_WRSR_END`.

Top module: `flash_status_ctrl`

## Requirements
- R1: Opcode 0x06, followed by chip select rising directly after its eighth bit, sets the write-enable latch (status bit 1).
- R2: A write-enable frame that ends before its eighth bit, or that carries extra serial clocks after it, leaves the latch unchanged.
- R3: Opcode 0x01 followed by one data byte, with the latch set, copies data bit 7 to status bit 7 (write-disable) and data bits 4:2 to status bits 4:2 (block protect). Status bits 6 and 5 always read 0, and data bits 1 and 0 are not stored.
- R4: A status write issued while the write-enable latch is clear leaves the status register unchanged.
- R5: A status write whose chip select rises before the eighth data bit, or after extra serial clocks, is discarded.
- R6: An accepted status write sets the busy flag (status bit 0) for `WRITE_CYCLES` system clocks. When the busy flag clears, the write-enable latch clears too.
- R7: When status bit 7 is 1 and the write-protect pin is low, status writes are ignored and the latch keeps its value. With the pin high, the same write is accepted.
- R8: Opcode 0x05 returns the status register MSB first, changing on falling serial clock edges. It repeats with a fresh copy every eight bits for as long as chip select stays low.
- R9: While busy, write-enable and status-write commands are ignored. Status reads still work.
- R10: The output enable is low whenever chip select is high and throughout any frame that is not a status read.
- R11: After reset the status register reads 0x00.
- R12: An unknown opcode causes the rest of its frame to be ignored, including any bytes that look like commands.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock that oversamples the link |
| rst_n | input | 1 | Asynchronous active-low reset |
| cs_n | input | 1 | Chip select, active low |
| sck | input | 1 | Serial clock, mode 0 |
| mosi | input | 1 | Serial data in, MSB first |
| wp_n | input | 1 | Write-protect pin, active low |
| miso | output | 1 | Serial data out |
| miso_oe | output | 1 | Output enable for the serial data out driver |

## Verification
The hardest condition to reach from the ports is a second command that arrives while the self-timed cycle is still running. The stimulus reaches it by issuing a new write-enable and a different status write straight after an accepted write, well inside the busy window. It then polls inside one long read frame until busy drops, and confirms that the protect bits hold the first write's value. The same polling frame measures how long the busy period lasts, counted in bytes. Frames cut off one bit early, or stretched by one extra clock, exercise the rule that chip select must rise exactly on the byte boundary.

// File: rtl/fsc_pkg.sv
package fsc_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_OPCODE,
        ST_WREN_END,
        ST_WRSR_DATA,
        ST_WRSR_END,
        ST_READ,
        ST_DISCARD
    } fsc_state_e;

    localparam int unsigned BYTE_W   = 8;
    localparam logic [7:0]  OP_WREN  = 8'h06;
    localparam logic [7:0]  OP_WRSR  = 8'h01;
    localparam logic [7:0]  OP_RDSR  = 8'h05;

    localparam int unsigned BIT_SRWD = 7;
    localparam int unsigned BP_HI    = 4;
    localparam int unsigned BP_LO    = 2;
    localparam int unsigned BP_W     = BP_HI - BP_LO + 1;

endpackage

// File: rtl/fsc_in_sync.sv
module fsc_in_sync #(
    parameter int unsigned     N       = 4,
    parameter int unsigned     STAGES  = 2,
    parameter logic [N-1:0]    RST_VAL = '0
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [N-1:0] din,
    output logic [N-1:0] dout
);

    logic [N-1:0] stg [STAGES];

    for (genvar g = 0; g < STAGES; g++) begin : g_stage
        if (g == 0) begin : g_first
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) stg[0] <= RST_VAL;
                else        stg[0] <= din;
            end
        end else begin : g_rest
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) stg[g] <= RST_VAL;
                else        stg[g] <= stg[g-1];
            end
        end
    end

    assign dout = stg[STAGES-1];

endmodule

// File: rtl/fsc_rx_shift.sv
module fsc_rx_shift #(
    parameter int unsigned W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         clear,
    input  logic         shift_en,
    input  logic         din,
    output logic         byte_done,
    output logic [W-1:0] byte_val
);

    localparam int unsigned CW = $clog2(W);
    localparam logic [CW-1:0] LAST = CW'(W - 1);

    logic [W-1:0]  sh_q;
    logic [CW-1:0] cnt_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sh_q  <= '0;
            cnt_q <= '0;
        end else if (clear) begin
            sh_q  <= '0;
            cnt_q <= '0;
        end else if (shift_en) begin
            sh_q  <= {sh_q[W-2:0], din};
            cnt_q <= (cnt_q == LAST) ? '0 : cnt_q + 1'b1;
        end
    end

    assign byte_done = shift_en && !clear && (cnt_q == LAST);
    assign byte_val  = {sh_q[W-2:0], din};

endmodule

// File: rtl/fsc_tx_shift.sv
module fsc_tx_shift #(
    parameter int unsigned W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         active,
    input  logic         shift_en,
    input  logic [W-1:0] load_val,
    output logic         dout
);

    localparam int unsigned CW = $clog2(W);
    localparam logic [CW-1:0] LAST = CW'(W - 1);

    logic [W-1:0]  sh_q;
    logic [CW-1:0] cnt_q;

    // Idle parks the counter on the last slot, so the first falling edge
    // of a read loads a fresh copy of the register.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sh_q  <= '0;
            cnt_q <= LAST;
        end else if (!active) begin
            sh_q  <= '0;
            cnt_q <= LAST;
        end else if (shift_en) begin
            if (cnt_q == LAST) begin
                sh_q  <= load_val;
                cnt_q <= '0;
            end else begin
                sh_q  <= {sh_q[W-2:0], 1'b0};
                cnt_q <= cnt_q + 1'b1;
            end
        end
    end

    assign dout = sh_q[W-1];

endmodule

// File: rtl/fsc_write_timer.sv
module fsc_write_timer #(
    parameter int unsigned CYCLES = 1024
) (
    input  logic clk,
    input  logic rst_n,
    input  logic start,
    output logic busy,
    output logic done
);

    localparam int unsigned CW = $clog2(CYCLES + 1);
    localparam logic [CW-1:0] LOAD = CW'(CYCLES);

    logic [CW-1:0] cnt_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)                     cnt_q <= '0;
        else if (start && cnt_q == '0)  cnt_q <= LOAD;
        else if (cnt_q != '0)           cnt_q <= cnt_q - 1'b1;
    end

    assign busy = (cnt_q != '0);
    assign done = (cnt_q == CW'(1));

endmodule

// File: rtl/flash_status_ctrl.sv
module flash_status_ctrl
    import fsc_pkg::*;
#(
    parameter int unsigned WRITE_CYCLES = 1024,
    parameter int unsigned SYNC_STAGES  = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic cs_n,
    input  logic sck,
    input  logic mosi,
    input  logic wp_n,
    output logic miso,
    output logic miso_oe
);

    localparam int unsigned NSYNC = 4;

    // synchronized pins
    logic [NSYNC-1:0] sy;
    logic cs_s, sck_s, mosi_s, wp_n_s;
    logic cs_prev, sck_prev;
    logic cs_rise, cs_low, sck_rise, sck_fall;

    fsc_in_sync #(
        .N       (NSYNC),
        .STAGES  (SYNC_STAGES),
        .RST_VAL (4'b1001)
    ) u_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .din   ({wp_n, mosi, sck, cs_n}),
        .dout  (sy)
    );

    assign cs_s   = sy[0];
    assign sck_s  = sy[1];
    assign mosi_s = sy[2];
    assign wp_n_s = sy[3];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cs_prev  <= 1'b1;
            sck_prev <= 1'b0;
        end else begin
            cs_prev  <= cs_s;
            sck_prev <= sck_s;
        end
    end

    assign cs_rise  = cs_s & ~cs_prev;
    assign cs_low   = ~cs_s;
    assign sck_rise = sck_s & ~sck_prev & cs_low;
    assign sck_fall = ~sck_s & sck_prev & cs_low;

    // byte receiver
    logic              byte_done;
    logic [BYTE_W-1:0] byte_val;

    fsc_rx_shift #(.W(BYTE_W)) u_rx (
        .clk       (clk),
        .rst_n     (rst_n),
        .clear     (~cs_low),
        .shift_en  (sck_rise),
        .din       (mosi_s),
        .byte_done (byte_done),
        .byte_val  (byte_val)
    );

    // status fields and timer
    logic            srwd_q;
    logic [BP_W-1:0] bp_q;
    logic            wel_q;
    logic            tmr_busy, tmr_done;
    logic [7:0]      status_w;

    // state machine signals
    fsc_state_e        st_q, st_d;
    logic [BYTE_W-1:0] data_q;
    logic              wel_set, wr_commit, hw_prot;

    fsc_write_timer #(.CYCLES(WRITE_CYCLES)) u_tmr (
        .clk   (clk),
        .rst_n (rst_n),
        .start (wr_commit),
        .busy  (tmr_busy),
        .done  (tmr_done)
    );

    assign status_w = {srwd_q, 2'b00, bp_q, wel_q, tmr_busy};
    assign hw_prot  = srwd_q & ~wp_n_s;

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q   <= ST_IDLE;
            data_q <= '0;
        end else begin
            st_q <= st_d;
            if (st_q == ST_WRSR_DATA && byte_done) data_q <= byte_val;
        end
    end

    // next state
    always_comb begin
        st_d = st_q;
        if (!cs_low) begin
            st_d = ST_IDLE;
        end else begin
            unique case (st_q)
                ST_IDLE:      st_d = ST_OPCODE;
                ST_OPCODE: begin
                    if (byte_done) begin
                        case (byte_val)
                            OP_RDSR: st_d = ST_READ;
                            OP_WREN: st_d = tmr_busy ? ST_DISCARD : ST_WREN_END;
                            OP_WRSR: st_d = tmr_busy ? ST_DISCARD : ST_WRSR_DATA;
                            default: st_d = ST_DISCARD;
                        endcase
                    end
                end
                ST_WREN_END:  if (sck_rise)  st_d = ST_DISCARD;
                ST_WRSR_DATA: if (byte_done) st_d = ST_WRSR_END;
                ST_WRSR_END:  if (sck_rise)  st_d = ST_DISCARD;
                ST_READ:      st_d = ST_READ;
                ST_DISCARD:   st_d = ST_DISCARD;
                default:      st_d = ST_IDLE;
            endcase
        end
    end

    // outputs of the state machine
    always_comb begin
        wel_set   = (st_q == ST_WREN_END) && cs_rise && !tmr_busy;
        wr_commit = (st_q == ST_WRSR_END) && cs_rise && !tmr_busy
                    && wel_q && !hw_prot;
        miso_oe   = (st_q == ST_READ);
    end

    // status register fields
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            srwd_q <= 1'b0;
            bp_q   <= '0;
            wel_q  <= 1'b0;
        end else begin
            if (wr_commit) begin
                srwd_q <= data_q[BIT_SRWD];
                bp_q   <= data_q[BP_HI:BP_LO];
            end
            if (wel_set)       wel_q <= 1'b1;
            else if (tmr_done) wel_q <= 1'b0;
        end
    end

    // status transmitter
    fsc_tx_shift #(.W(BYTE_W)) u_tx (
        .clk      (clk),
        .rst_n    (rst_n),
        .active   (st_q == ST_READ),
        .shift_en (sck_fall),
        .load_val (status_w),
        .dout     (miso)
    );

endmodule

// File: rtl/flash_status_ctrl_chk.sv
module flash_status_ctrl_chk #(
    parameter int unsigned WRITE_CYCLES = 1024,
    parameter int unsigned SYNC_STAGES  = 2
) (
    input logic       clk,
    input logic       rst_n,
    input logic       cs_n,
    input logic       miso_oe,
    input logic [7:0] status,
    input logic       cs_rise,
    input logic       wp_n_s
);

    int unsigned cs_hi_cnt;
    int unsigned busy_run;
    logic [3:0]  prot;

    assign prot = {status[7], status[4:2]};

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cs_hi_cnt <= 0;
            busy_run  <= 0;
        end else begin
            cs_hi_cnt <= cs_n ? ((cs_hi_cnt < 15) ? cs_hi_cnt + 1 : cs_hi_cnt) : 0;
            busy_run  <= status[0] ? busy_run + 1 : 0;
        end
    end

    p_oe_idle_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (cs_hi_cnt > SYNC_STAGES + 2) |-> !miso_oe);

    p_wel_clear_r6: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(status[0]) |-> !status[1]);

    p_busy_len_r6: assert property (@(posedge clk) disable iff (!rst_n)
        busy_run <= WRITE_CYCLES);

    p_prot_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (cs_rise && status[7] && !wp_n_s) |=> $stable(prot));

    p_need_wel_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (prot != $past(prot)) |-> $past(status[1]));

    p_busy_on_write_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (prot != $past(prot)) |-> status[0]);

    p_busy_blocks_r9: assert property (@(posedge clk) disable iff (!rst_n)
        $past(status[0]) |-> $stable(prot));

    p_zero_bits_r3: assert property (@(posedge clk) disable iff (!rst_n)
        status[6:5] == 2'b00);

endmodule

bind flash_status_ctrl flash_status_ctrl_chk #(
    .WRITE_CYCLES (WRITE_CYCLES),
    .SYNC_STAGES  (SYNC_STAGES)
) i_chk (
    .clk     (clk),
    .rst_n   (rst_n),
    .cs_n    (cs_n),
    .miso_oe (miso_oe),
    .status  (status_w),
    .cs_rise (cs_rise),
    .wp_n_s  (wp_n_s)
);

// File: tb/test_flash_status_ctrl.sv
`timescale 1ns/1ps
module test_flash_status_ctrl;

    localparam int WC = 2000;
    localparam int H  = 6;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic cs_n = 1'b1, sck = 1'b0, mosi = 1'b0, wp_n = 1'b1;
    logic miso, miso_oe;

    int total = 0;
    int bad = 0;
    int clk_bad = 0;
    int hi_cnt = 0;
    logic [7:0] m_st;   // model of the status register

    always #4 clk = ~clk;

    flash_status_ctrl #(.WRITE_CYCLES(WC), .SYNC_STAGES(2)) i_flash_status_ctrl (
        .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .sck(sck), .mosi(mosi),
        .wp_n(wp_n), .miso(miso), .miso_oe(miso_oe)
    );

    // per-clock comparison of the output enable against the model (R10)
    always @(negedge clk) begin
        if (!rst_n) hi_cnt = 0;
        else begin
            hi_cnt = cs_n ? hi_cnt + 1 : 0;
            if (hi_cnt > 4 && miso_oe) clk_bad++;
        end
    end

    task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic hwait(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic cs_on();
        @(negedge clk); cs_n = 1'b0; hwait(H);
    endtask

    task automatic cs_off();
        hwait(H); cs_n = 1'b1; hwait(3 * H);
    endtask

    // shifts n bits of tx (MSB first); checks output enable before each rise
    task automatic xfer(input logic [7:0] tx, input int n, input logic exp_oe,
                        input string req, output logic [7:0] rx);
        rx = '0;
        for (int i = 0; i < n; i++) begin
            mosi = tx[7 - (i % 8)];
            hwait(H);
            rx = {rx[6:0], miso};
            if (miso_oe !== exp_oe) begin
                total++; bad++;
                $display("FAIL %s oe actual=%b expected=%b", req, miso_oe, exp_oe);
            end
            sck = 1'b1;
            hwait(H);
            sck = 1'b0;
        end
    endtask

    task automatic cmd(input logic [7:0] op, input int nbits);
        logic [7:0] d;
        cs_on();
        xfer(op, nbits, 1'b0, "R10", d);
        cs_off();
    endtask

    task automatic wrsr(input logic [7:0] data, input int dbits);
        logic [7:0] d;
        cs_on();
        xfer(8'h01, 8, 1'b0, "R10", d);
        if (dbits > 8) begin
            xfer(data, 8, 1'b0, "R10", d);
            xfer(8'h00, dbits - 8, 1'b0, "R10", d);
        end else begin
            xfer(data, dbits, 1'b0, "R10", d);
        end
        cs_off();
    endtask

    task automatic rdsr(input int nbytes, output logic [7:0] q[$]);
        logic [7:0] d;
        q = {};
        cs_on();
        xfer(8'h05, 8, 1'b0, "R10", d);
        for (int b = 0; b < nbytes; b++) begin
            xfer(8'h00, 8, 1'b1, "R8", d);
            q.push_back(d);
        end
        cs_off();
    endtask

    // polls busy within one frame; returns first byte, last byte, busy count
    task automatic poll(output logic [7:0] first, output logic [7:0] last, output int nb);
        logic [7:0] d;
        nb = 0;
        cs_on();
        xfer(8'h05, 8, 1'b0, "R10", d);
        for (int b = 0; b < 60; b++) begin
            xfer(8'h00, 8, 1'b1, "R8", d);
            if (b == 0) first = d;
            last = d;
            if (d[0]) nb++;
            else break;
        end
        cs_off();
    endtask

    task automatic read_chk(input string req);
        logic [7:0] q[$];
        rdsr(1, q);
        chk(req, q[0], m_st);
    endtask

    task automatic summary();
        total++;
        if (clk_bad != 0) begin
            bad++;
            $display("FAIL R10 oe-per-clock actual=%0d expected=0", clk_bad);
        end
        $display("  test done: total=%0d bad=%0d", total, bad);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        total++; bad++;
        $display("FAIL watchdog actual=timeout expected=finish");
        summary();
        $finish;
    end

    initial begin
        logic [7:0] q[$];
        logic [7:0] f, l;
        int nb;

        hwait(5);
        rst_n = 1'b1;
        hwait(10);

        // R11 reset state
        m_st = 8'h00;
        chk("R11 oe", {7'd0, miso_oe}, 8'h00);
        read_chk("R11");

        // R1 write enable
        cmd(8'h06, 8);
        m_st = 8'h02;
        read_chk("R1");

        // R3/R6 accepted write, busy polling
        wrsr(8'hFF, 8);
        poll(f, l, nb);
        chk("R3 first poll byte", f, 8'h9F);
        chk("R6 end byte wel cleared", l, 8'h9C);
        total++;
        if (nb < WC / (16 * H) - 3 || nb > WC / (16 * H) + 2) begin
            bad++;
            $display("FAIL R6 busy bytes actual=%0d expected=%0d..%0d",
                     nb, WC / (16 * H) - 3, WC / (16 * H) + 2);
        end
        m_st = 8'h9C;

        // R8 repeated read with a stable register
        rdsr(3, q);
        chk("R8 byte0", q[0], m_st);
        chk("R8 byte1", q[1], m_st);
        chk("R8 byte2", q[2], m_st);

        // R7 hardware protection
        wp_n = 1'b0;
        cmd(8'h06, 8);
        m_st = 8'h9E;
        wrsr(8'h00, 8);
        read_chk("R7 protected write ignored");
        wp_n = 1'b1;
        wrsr(8'h00, 8);
        poll(f, l, nb);
        chk("R7 unprotected write busy", f, 8'h03);
        m_st = 8'h00;
        chk("R7 unprotected write result", l, m_st);

        // R4 write without enable
        wrsr(8'h1C, 8);
        read_chk("R4");

        // R2 malformed enable frames
        cmd(8'h06, 9);
        read_chk("R2 extra clock");
        cmd(8'h06, 7);
        read_chk("R2 short frame");

        // R5 malformed status-write frames
        cmd(8'h06, 8);
        m_st = 8'h02;
        wrsr(8'h1C, 7);
        read_chk("R5 short data");
        wrsr(8'h1C, 9);
        read_chk("R5 extra clock");
        wrsr(8'h0C, 8);
        poll(f, l, nb);
        m_st = 8'h0C;
        chk("R5 full frame accepted", l, m_st);

        // R9 commands during busy
        cmd(8'h06, 8);
        wrsr(8'h10, 8);
        cmd(8'h06, 8);
        wrsr(8'h8C, 8);
        poll(f, l, nb);
        chk("R9 busy read works", f, 8'h13);
        m_st = 8'h10;
        chk("R9 write while busy ignored", l, m_st);

        // R12 unknown opcode, rest of frame ignored
        cmd(8'h06, 8);
        m_st = 8'h12;
        begin
            logic [7:0] d;
            cs_on();
            xfer(8'hAB, 8, 1'b0, "R12", d);
            xfer(8'h01, 8, 1'b0, "R12", d);
            xfer(8'hFF, 8, 1'b0, "R12", d);
            cs_off();
        end
        read_chk("R12");

        hwait(20);
        summary();
        $finish;
    end

endmodule